// File: doc/BRIEF.md
# Register-Prefix Two-Wire Slave for a Supply Controller

This block is the serial control port of a supply controller. It answers a 7-bit two-wire (I2C) address and holds three small control registers. The upper five address bits are fixed, and the two lowest bits come from strap pins, so four controllers can share one bus. There is no separate register pointer. Each written byte names its own target in its top three bits and carries five bits of payload in the rest. A read streams the register set back to the master, with live fault flags folded into the first register, until the master declines a byte.

SCL and SDA are taken through synchronizers on a system clock that runs at least 16 times faster than SCL. Spike filtering and the open-drain pads sit outside the block. The only drive the block puts on the bus is a pull-low request for SDA. A power-good input gates the whole interface: while it is low, the block stays silent and every register reads zero.

Top module: `pwr_i2c_regs`

## Requirements
- R1: A byte after START is taken as an address. The block acknowledges it (pulls SDA low during the ninth clock) only if bits [7:1] equal 0b00010 followed by the pin values {pin1, pin0}. Bit 0 is the direction bit, with 1 meaning read and 0 meaning write.
- R2: In a written data byte, bits [7:5] select the target register and bits [4:0] are stored into it. Code 001 selects `tone_o`, code 010 selects `lim_o` and code 011 selects `volt_o`.
- R3: Data bytes with select code 000 (the read-only status slot) or with codes 100 through 111 are acknowledged but leave all three registers unchanged.
- R4: One write transfer may carry any number of data bytes. Each byte is acknowledged and applied in turn.
- R5: A read transfer returns bytes MSB first in the order status, tone, limit, voltage, and then repeats that order. Each byte is {3-bit select code, 5-bit payload}. The status payload is `status_i` as it stands when the byte is loaded.
- R6: A master ACK after a read byte starts the next byte. A NACK ends the transfer, and the block then leaves SDA released for all following clocks until the next START.
- R7: While `pwr_ok_i` is low, the block acknowledges nothing, keeps SDA released, and holds all registers at zero, starting one clock after the input falls.
- R8: After reset, all registers are zero and SDA is released.
- R9: A START that arrives during any transfer restarts the address phase. After a STOP, bus clocks without a new START are ignored.
- R10: The block begins pulling SDA low only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 16x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply good; low silences and clears the interface |
| addr_pins_i | input | 2 | Strap pins forming address bits 1:0 |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| status_i | input | 5 | Live fault flags, read back in the status slot |
| sda_low_o | output | 1 | Request to pull SDA low |
| tone_o | output | 5 | Tone register payload |
| lim_o | output | 5 | Current-limit register payload |
| volt_o | output | 5 | Voltage register payload |

## Verification
Two functions can meet in the same cycle: a change of the live status flags and the load of a status byte into the read shifter. The bench changes `status_i` while a read is in flight. It then expects the byte already on the wire to keep the old flags and the next status slot, four bytes later, to carry the new ones. A second meeting point is a register write followed at once by a repeated START into a read. There the bench checks that the write landed and that the read restarts at the status slot.

// File: rtl/pwr_i2c_pkg.sv
package pwr_i2c_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 3;
  localparam int PAY_W    = BYTE_W - SEL_W;
  localparam int NREG     = 4;
  localparam int PTR_W    = $clog2(NREG);
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int PFX_W    = 5;
  localparam int PIN_W    = 2;
  localparam int SEL_TONE = 1;
  localparam int SEL_LIM  = 2;
  localparam int SEL_VOLT = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_o   = scl_q[STAGES-1];
  assign sda_o   = sda_q[STAGES-1];
  assign start_o = scl_o && scl_p && sda_p && !sda_o;
  assign stop_o  = scl_o && scl_p && !sda_p && sda_o;
  assign rise_o  = scl_o && !scl_p;
  assign fall_o  = !scl_o && scl_p;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import pwr_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic [BYTE_W-2:0] dev_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_low_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              rd_rewind_o,
  output logic              rd_adv_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  bus_st_e           st;
  logic [BYTE_W-1:0] sh, tx;
  logic [CNT_W-1:0]  cnt;
  logic              byte_done, rw, mst_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      sh          <= '0;
      tx          <= '0;
      cnt         <= '0;
      byte_done   <= 1'b0;
      rw          <= 1'b0;
      mst_ack     <= 1'b0;
      sda_low_o   <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_byte_o   <= '0;
      rd_rewind_o <= 1'b0;
      rd_adv_o    <= 1'b0;
    end else begin
      wr_en_o     <= 1'b0;
      rd_rewind_o <= 1'b0;
      rd_adv_o    <= 1'b0;
      if (!pwr_ok_i) begin
        st        <= ST_IDLE;
        sda_low_o <= 1'b0;
        byte_done <= 1'b0;
        cnt       <= '0;
      end else if (start_i) begin
        st        <= ST_ADDR;
        sda_low_o <= 1'b0;
        byte_done <= 1'b0;
        cnt       <= '0;
      end else if (stop_i) begin
        st        <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        if (rise_i && (st == ST_ADDR || st == ST_WR)) begin
          sh  <= {sh[BYTE_W-2:0], sda_i};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) byte_done <= 1'b1;
        end
        if (rise_i && st == ST_RD_ACK) mst_ack <= !sda_i;
        if (fall_i) begin
          unique case (st)
            ST_ADDR: if (byte_done) begin
              byte_done <= 1'b0;
              cnt       <= '0;
              if (sh[BYTE_W-1:1] == dev_addr_i) begin
                sda_low_o   <= 1'b1;
                rw          <= sh[0];
                rd_rewind_o <= 1'b1;
                st          <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_ADDR_ACK: begin
              cnt <= '0;
              if (rw) begin
                tx        <= rd_byte_i;
                sda_low_o <= !rd_byte_i[BYTE_W-1];
                rd_adv_o  <= 1'b1;
                st        <= ST_RD;
              end else begin
                sda_low_o <= 1'b0;
                st        <= ST_WR;
              end
            end
            ST_WR: if (byte_done) begin
              byte_done <= 1'b0;
              cnt       <= '0;
              wr_en_o   <= 1'b1;
              wr_byte_o <= sh;
              sda_low_o <= 1'b1;
              st        <= ST_WR_ACK;
            end
            ST_WR_ACK: begin
              sda_low_o <= 1'b0;
              st        <= ST_WR;
            end
            ST_RD: begin
              if (cnt == LAST) begin
                sda_low_o <= 1'b0;
                st        <= ST_RD_ACK;
              end else begin
                cnt       <= cnt + 1'b1;
                tx        <= {tx[BYTE_W-2:0], 1'b0};
                sda_low_o <= !tx[BYTE_W-2];
              end
            end
            ST_RD_ACK: begin
              cnt <= '0;
              if (mst_ack) begin
                tx        <= rd_byte_i;
                sda_low_o <= !rd_byte_i[BYTE_W-1];
                rd_adv_o  <= 1'b1;
                st        <= ST_RD;
              end else begin
                sda_low_o <= 1'b0;
                st        <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R7
  pwr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !sda_low_o);

  // R10
  sda_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !scl_i);
endmodule

// File: rtl/sel_regfile.sv
module sel_regfile
  import pwr_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_rewind_i,
  input  logic              rd_adv_i,
  input  logic [PAY_W-1:0]  status_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic [PAY_W-1:0]  tone_o,
  output logic [PAY_W-1:0]  lim_o,
  output logic [PAY_W-1:0]  volt_o
);
  logic [SEL_W-1:0] wr_sel;
  logic [PAY_W-1:0] view [NREG];
  logic [PTR_W-1:0] rd_ptr;

  assign wr_sel  = wr_byte_i[BYTE_W-1 -: SEL_W];
  assign view[0] = status_i;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic [PAY_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (!pwr_ok_i)                         q <= '0;
      else if (wr_en_i && wr_sel == SEL_W'(g))    q <= wr_byte_i[PAY_W-1:0];
    end
    assign view[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rd_ptr <= '0;
    else if (!pwr_ok_i || rd_rewind_i) rd_ptr <= '0;
    else if (rd_adv_i)                rd_ptr <= rd_ptr + 1'b1;
  end

  assign rd_byte_o = {SEL_W'(rd_ptr), view[rd_ptr]};
  assign tone_o    = view[SEL_TONE];
  assign lim_o     = view[SEL_LIM];
  assign volt_o    = view[SEL_VOLT];

  // R7
  pwr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (tone_o == '0 && lim_o == '0 && volt_o == '0));

  // R3
  unused_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pwr_ok_i && (wr_sel == '0 || wr_sel >= SEL_W'(NREG)))
      |=> ($stable(tone_o) && $stable(lim_o) && $stable(volt_o)));

  // R2
  tone_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pwr_ok_i && wr_sel == SEL_W'(SEL_TONE))
      |=> tone_o == $past(wr_byte_i[PAY_W-1:0]));
endmodule

// File: rtl/pwr_i2c_regs.sv
module pwr_i2c_regs
  import pwr_i2c_pkg::*;
#(
  parameter logic [PFX_W-1:0] DEV_PREFIX  = 5'b00010,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic [PIN_W-1:0] addr_pins_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PAY_W-1:0] status_i,
  output logic             sda_low_o,
  output logic [PAY_W-1:0] tone_o,
  output logic [PAY_W-1:0] lim_o,
  output logic [PAY_W-1:0] volt_o
);
  logic scl_s, sda_s, start, stop, rise, fall;
  logic wr_en, rd_rewind, rd_adv;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall)
  );

  i2c_byte_fsm u_fsm (
    .clk_i, .rst_ni, .pwr_ok_i,
    .dev_addr_i({DEV_PREFIX, addr_pins_i}),
    .scl_i(scl_s), .sda_i(sda_s), .start_i(start), .stop_i(stop),
    .rise_i(rise), .fall_i(fall), .rd_byte_i(rd_byte),
    .sda_low_o, .wr_en_o(wr_en), .wr_byte_o(wr_byte),
    .rd_rewind_o(rd_rewind), .rd_adv_o(rd_adv)
  );

  sel_regfile u_regs (
    .clk_i, .rst_ni, .pwr_ok_i,
    .wr_en_i(wr_en), .wr_byte_i(wr_byte),
    .rd_rewind_i(rd_rewind), .rd_adv_i(rd_adv),
    .status_i, .rd_byte_o(rd_byte),
    .tone_o, .lim_o, .volt_o
  );
endmodule

// File: tb/pwr_i2c_regs_test.sv
module pwr_i2c_regs_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, pwr_ok = 1'b1;
  logic [1:0] apins = 2'b00;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] status = 5'b00000;
  logic       sda_low;
  logic [4:0] tone, lim, volt;
  wire        sda_bus = sda_m & ~sda_low;

  logic [4:0] m_tone = '0, m_lim = '0, m_volt = '0;
  int total = 0, bad = 0;

  pwr_i2c_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .addr_pins_i(apins),
    .scl_i(scl_m), .sda_i(sda_bus), .status_i(status), .sda_low_o(sda_low),
    .tone_o(tone), .lim_o(lim), .volt_o(volt)
  );

  task automatic wq();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_byte(input logic ack_m, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = !ack_m; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  function automatic logic [14:0] regs_now();
    return {tone, lim, volt};
  endfunction

  function automatic logic [14:0] regs_exp();
    return {m_tone, m_lim, m_volt};
  endfunction

  function automatic void model_wr(input logic [7:0] b);
    case (b[7:5])
      3'd1: m_tone = b[4:0];
      3'd2: m_lim  = b[4:0];
      3'd3: m_volt = b[4:0];
      default: ;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] rb, wb;
    logic [7:0] aw, ar;

    // R8 reset state
    repeat (4) @(posedge clk); #1;
    chk("R8 regs at reset", regs_now(), 15'd0);
    chk("R8 sda at reset", sda_low, 1'b0);
    rst_n = 1'b1;
    wq();

    // R1 address sweep over pins and candidate addresses
    for (int p = 0; p < 4; p++) begin
      apins = p[1:0];
      for (int a = 0; a < 4; a++) begin
        do_start();
        put_byte({5'b00010, a[1:0], 1'b0}, ack);
        do_stop();
        chk($sformatf("R1 pins=%0d addr=%0d", p, a), ack, (a == p));
      end
    end
    do_start(); put_byte({7'h18, 1'b0}, ack); do_stop();
    chk("R1 foreign prefix", ack, 1'b0);

    apins = 2'b10;
    aw = {5'b00010, 2'b10, 1'b0};
    ar = {5'b00010, 2'b10, 1'b1};

    // R2 / R3 select sweep, one byte per transfer
    for (int s = 0; s < 8; s++) begin
      wb = {s[2:0], 5'((s * 5 + 3) & 31)};
      do_start(); put_byte(aw, ack); put_byte(wb, ack); do_stop();
      chk($sformatf("R3 data ack sel=%0d", s), ack, 1'b1);
      model_wr(wb);
      if (s >= 1 && s <= 3) chk($sformatf("R2 sel=%0d", s), regs_now(), regs_exp());
      else                  chk($sformatf("R3 sel=%0d unchanged", s), regs_now(), regs_exp());
    end

    // R4 long write transfer through all payload values
    do_start(); put_byte(aw, ack);
    for (int v = 0; v < 32; v++) begin
      for (int s = 1; s < 4; s++) begin
        wb = {s[2:0], (s == 1) ? v[4:0] : (s == 2) ? ~v[4:0] : (v[4:0] ^ 5'h15)};
        put_byte(wb, ack);
        model_wr(wb);
        chk($sformatf("R4 ack v=%0d s=%0d", v, s), ack, 1'b1);
        chk($sformatf("R4 regs v=%0d s=%0d", v, s), regs_now(), regs_exp());
      end
    end
    do_stop();

    // R5 / R6 sequential read with status change mid transfer
    status = 5'b10110;
    do_start(); put_byte(ar, ack);
    chk("R1 read addr ack", ack, 1'b1);
    for (int k = 0; k < 6; k++) begin
      logic [4:0] pay;
      get_byte(k < 5, rb);
      case (k % 4)
        0: pay = (k == 0) ? 5'b10110 : 5'b01001;
        1: pay = m_tone;
        2: pay = m_lim;
        default: pay = m_volt;
      endcase
      chk($sformatf("R5 read byte %0d", k), rb, {3'(k % 4), pay});
      if (k == 0) status = 5'b01001;
    end
    get_byte(1'b0, rb);
    chk("R6 silent after nack", rb, 8'hFF);
    do_stop();

    // R9 repeated start from write into read
    do_start(); put_byte(aw, ack); put_byte({3'd2, 5'h0A}, ack);
    model_wr({3'd2, 5'h0A});
    do_start(); put_byte(ar, ack);
    chk("R9 restart addr ack", ack, 1'b1);
    get_byte(1'b0, rb);
    do_stop();
    chk("R9 restart reads status", rb, {3'd0, status});
    chk("R9 write before restart", regs_now(), regs_exp());

    // R9 clocks after stop without start are ignored
    scl_m = 1'b0; wq();
    put_byte(aw, ack);
    chk("R9 no ack without start", ack, 1'b0);
    scl_m = 1'b1; wq(); wq();

    // R7 power-good low
    pwr_ok = 1'b0;
    repeat (2) @(posedge clk); #1;
    m_tone = '0; m_lim = '0; m_volt = '0;
    chk("R7 regs cleared", regs_now(), 15'd0);
    do_start(); put_byte(aw, ack);
    chk("R7 no addr ack", ack, 1'b0);
    put_byte({3'd3, 5'h1F}, ack);
    do_stop();
    chk("R7 no data ack", ack, 1'b0);
    chk("R7 regs stay zero", regs_now(), 15'd0);
    pwr_ok = 1'b1; wq();
    do_start(); put_byte(aw, ack); put_byte({3'd3, 5'h11}, ack); do_stop();
    model_wr({3'd3, 5'h11});
    chk("R7 ack after power back", ack, 1'b1);
    chk("R7 write after power back", regs_now(), regs_exp());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule